// File: doc/BRIEF.md
# Integration-cycle clock correction unit

This block keeps a node's local time within a repeating integration cycle and corrects it once per cycle from the arrival times of synchronisation frames. Each frame arrives on one of several input lanes together with the transparent-clock delay it gathered on its way. The block turns each arrival into a permanence offset, which is how far the frame's fixed-delay arrival point lies from the scheduled receive point. Frames whose offset falls outside a window around that point are dropped.

A role input selects how the offsets are reduced. As a compression master, the block listens to every master lane. It trims the largest and smallest offsets when at least three are present and averages what remains. It then asks for a fresh synchronisation frame to be sent. As a synchronisation master, it listens only to its compression-master channels and takes their median. With two channels, the median is their mean.

At a fixed point in each cycle, the resulting error is subtracted from the local time in a single clock. A strobe reports the error. A flag goes high when no frame arrived during the cycle.

Top module: `sync_corr_unit`

## Requirements
- R1: After reset, `local_time` advances by `TICK_NS` on every clock and wraps modulo `CYCLE_NS`, except on the clock where a correction is applied.
- R2: A frame on lane i (`frm_vld[i]`, delay on `frm_tc[i*TW +: TW]`) has the offset d = local_time + `MAXD_NS` − tc − `SCHED_NS`, where local_time is the value at the accepting edge. The frame is accepted only if −`WIN_NS` ≤ d ≤ `WIN_NS`. Any other frame has no effect.
- R3: Only the first accepted frame of a lane in a cycle counts. Later frames on that lane in the same cycle are ignored.
- R4: With `role_cm` = 1 (compression master), all `NUM_SM` lanes are used. With three or more accepted offsets, the largest and the smallest are removed and the remaining ones are averaged. With two offsets the error is their mean. With one offset the error is that offset. Every halving rounds toward minus infinity.
- R5: With `role_cm` = 0 (synchronisation master), only lanes 0 to `NUM_CH`−1 are used. Frames on the other lanes are ignored. The error is the mean of two channel offsets, or the single channel offset.
- R6: On the first clock of a cycle on which local_time ≥ `CORR_NS`, `corr_stb` pulses for one clock with the error on `corr_err`. At that same edge, local_time becomes (local_time + `TICK_NS` − error) modulo `CYCLE_NS`.
- R7: If no frame was accepted in the cycle, the error is 0 and `unsync` is 1. Otherwise `unsync` is 0. Both values hold until the next correction.
- R8: `tx_req` pulses together with `corr_stb` only in the compression-master role, and only when at least one frame was accepted.
- R9: During reset, local_time, `corr_err`, `corr_stb` and `tx_req` are 0 and `unsync` is 1.
- R10: A correction is applied at most once per cycle, even when it moves the local time back below `CORR_NS`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| role_cm | input | 1 | 1 = compression master, 0 = synchronisation master |
| frm_vld | input | NUM_SM | One-clock frame arrival per lane |
| frm_tc | input | NUM_SM*TW | Transparent-clock delay (ns) per lane |
| local_time | output | TW | Local time within the cycle (ns) |
| corr_err | output | TW | Signed error of the last correction (ns) |
| corr_stb | output | 1 | Correction applied on the previous edge |
| unsync | output | 1 | No frame accepted in the last cycle |
| tx_req | output | 1 | Request to send a new synchronisation frame |

## Verification
The bench aims at the window edges (±`WIN_NS` accepted, one nanosecond beyond rejected). A design with an off-by-one comparison would shift the error by hundreds of nanoseconds. It sends an outlier among four frames, which a plain average would let pull the clock. It sends odd sums of negative offsets, which expose rounding toward zero. It sends a repeated frame per lane, which shows a design that overwrites the first sample. It drives frames on the non-channel lanes in the synchronisation-master role. It also applies negative-going corrections that move the time back before the correction point, where a design without a once-per-cycle guard would correct twice.

// File: rtl/sync_corr_pkg.sv
// Shared definitions for the clock correction unit.
package sync_corr_pkg;
    // Role of the node in the two-step correction scheme.
    typedef enum logic {
        ROLE_SYNC_MASTER = 1'b0,
        ROLE_COMP_MASTER = 1'b1
    } role_e;
endpackage

// File: rtl/sync_corr_timebase.sv
// Local time counter for one integration cycle.
// Counts up by TICK_NS each clock and wraps at CYCLE_NS. On the first clock at or
// after CORR_NS in a cycle it raises corr_due and subtracts err in the same step.
// Assumes |err| is well below CYCLE_NS/2.
module sync_corr_timebase #(
    parameter int TW       = 20,
    parameter int CYCLE_NS = 80000,
    parameter int TICK_NS  = 8,
    parameter int CORR_NS  = 4400
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic signed [TW-1:0] err,
    output logic [TW-1:0]        local_time,
    output logic                 corr_due
);
    localparam int XW = TW + 2;
    localparam logic signed [XW-1:0] CYCLE_S = XW'(CYCLE_NS);
    localparam logic signed [XW-1:0] TICK_S  = XW'(TICK_NS);
    localparam logic [TW-1:0]        CORR_U  = TW'(CORR_NS);

    logic                 done_q;
    logic                 wrap;
    logic signed [XW-1:0] nxt;

    // Correction becomes due once per cycle when the time passes the point.
    assign corr_due = (local_time >= CORR_U) && !done_q;

    // Next time value including the optional correction and the modulo wrap.
    always_comb begin
        nxt  = $signed({2'b00, local_time}) + TICK_S
             - (corr_due ? {{2{err[TW-1]}}, err} : '0);
        wrap = 1'b0;
        if (nxt >= CYCLE_S) begin
            nxt  = nxt - CYCLE_S;
            wrap = 1'b1;
        end else if (nxt < 0) begin
            nxt = nxt + CYCLE_S;
        end
    end

    // Time register and the applied-this-cycle flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            local_time <= '0;
            done_q     <= 1'b0;
        end else begin
            local_time <= nxt[TW-1:0];
            if (wrap)          done_q <= 1'b0;
            else if (corr_due) done_q <= 1'b1;
        end
    end
endmodule

// File: rtl/sync_corr_lane.sv
// One receive lane: turns an arriving frame into a permanence offset relative
// to the scheduled point, keeps the first one inside the window, and is emptied
// when the correction is taken. Assumes the delay input does not exceed MAXD_NS.
module sync_corr_lane #(
    parameter int TW       = 20,
    parameter int SCHED_NS = 2000,
    parameter int WIN_NS   = 1000,
    parameter int MAXD_NS  = 400
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 en,
    input  logic                 vld,
    input  logic [TW-1:0]        tc,
    input  logic [TW-1:0]        local_time,
    input  logic                 clear,
    output logic                 hit,
    output logic signed [TW-1:0] ofs
);
    localparam int XW = TW + 2;
    localparam logic signed [XW-1:0] SCHED_S = XW'(SCHED_NS);
    localparam logic signed [XW-1:0] WIN_S   = XW'(WIN_NS);
    localparam logic signed [XW-1:0] MAXD_S  = XW'(MAXD_NS);

    logic signed [XW-1:0] d_c;
    logic                 in_win;

    // Permanence offset of a frame arriving now.
    always_comb begin
        d_c    = $signed({2'b00, local_time}) + MAXD_S - $signed({2'b00, tc}) - SCHED_S;
        in_win = (d_c >= -WIN_S) && (d_c <= WIN_S);
    end

    // Keep the first in-window offset of the cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hit <= 1'b0;
            ofs <= '0;
        end else if (clear) begin
            hit <= 1'b0;
        end else if (vld && en && !hit && in_win) begin
            hit <= 1'b1;
            ofs <= d_c[TW-1:0];
        end
    end
endmodule

// File: rtl/sync_corr_reduce.sv
// Reduces the captured offsets to one error. With three or more values the
// extremes are trimmed, and the remainder (one or two values) is averaged with
// floor rounding. Assumes N <= 4, so the divisor is always 1 or 2.
module sync_corr_reduce #(
    parameter int N  = 4,
    parameter int TW = 20
) (
    input  logic [N-1:0]         hit,
    input  logic [N*TW-1:0]      ofs,
    output logic signed [TW-1:0] err,
    output logic [$clog2(N+1)-1:0] cnt
);
    localparam int EW = TW + 3;
    localparam int CW = $clog2(N+1);

    logic signed [EW-1:0] v, sum, mx, mn, trim, res;

    // Sum, extremes and count of the valid offsets, then trimmed mean.
    always_comb begin
        v   = '0;
        sum = '0;
        cnt = '0;
        mx  = {1'b1, {(EW-1){1'b0}}};
        mn  = {1'b0, {(EW-1){1'b1}}};
        for (int i = 0; i < N; i++) begin
            if (hit[i]) begin
                v   = {{3{ofs[i*TW+TW-1]}}, ofs[i*TW +: TW]};
                sum = sum + v;
                cnt = cnt + CW'(1);
                if (v > mx) mx = v;
                if (v < mn) mn = v;
            end
        end
        trim = sum - mx - mn;
        if (cnt == CW'(0))      res = '0;
        else if (cnt == CW'(1)) res = sum;
        else if (cnt == CW'(2)) res = sum >>> 1;
        else if (cnt == CW'(3)) res = trim;
        else                    res = trim >>> 1;
        err = res[TW-1:0];
    end
endmodule

// File: rtl/sync_corr_unit.sv
// Clock correction unit for a time-triggered network node. It gathers the
// synchronisation frame offsets of one integration cycle, reduces them
// according to the role, corrects the local time once per cycle and, as a
// compression master, requests a new frame to be sent. Frame decoding lies
// outside this block.
module sync_corr_unit
    import sync_corr_pkg::*;
#(
    parameter int NUM_SM   = 4,
    parameter int NUM_CH   = 2,
    parameter int TW       = 20,
    parameter int CYCLE_NS = 80000,
    parameter int TICK_NS  = 8,
    parameter int SCHED_NS = 2000,
    parameter int WIN_NS   = 1000,
    parameter int MAXD_NS  = 400,
    parameter int CORR_NS  = 4400
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 role_cm,
    input  logic [NUM_SM-1:0]    frm_vld,
    input  logic [NUM_SM*TW-1:0] frm_tc,
    output logic [TW-1:0]        local_time,
    output logic signed [TW-1:0] corr_err,
    output logic                 corr_stb,
    output logic                 unsync,
    output logic                 tx_req
);
    localparam int CW = $clog2(NUM_SM + 1);

    role_e                  role;
    logic                   corr_due;
    logic [NUM_SM-1:0]      lane_en, lane_hit;
    logic [NUM_SM*TW-1:0]   lane_ofs;
    logic signed [TW-1:0]   err_c;
    logic [CW-1:0]          cnt_c;

    assign role = role_e'(role_cm);

    sync_corr_timebase #(
        .TW(TW), .CYCLE_NS(CYCLE_NS), .TICK_NS(TICK_NS), .CORR_NS(CORR_NS)
    ) u_tb (
        .clk(clk), .rst_n(rst_n), .err(err_c),
        .local_time(local_time), .corr_due(corr_due)
    );

    // One capture lane per master; the sync-master role listens to channels only.
    for (genvar i = 0; i < NUM_SM; i++) begin : g_lane
        if (i < NUM_CH) begin : g_ch
            assign lane_en[i] = 1'b1;
        end else begin : g_cm_only
            assign lane_en[i] = (role == ROLE_COMP_MASTER);
        end
        sync_corr_lane #(
            .TW(TW), .SCHED_NS(SCHED_NS), .WIN_NS(WIN_NS), .MAXD_NS(MAXD_NS)
        ) u_lane (
            .clk(clk), .rst_n(rst_n), .en(lane_en[i]), .vld(frm_vld[i]),
            .tc(frm_tc[i*TW +: TW]), .local_time(local_time), .clear(corr_due),
            .hit(lane_hit[i]), .ofs(lane_ofs[i*TW +: TW])
        );
    end

    sync_corr_reduce #(.N(NUM_SM), .TW(TW)) u_red (
        .hit(lane_hit), .ofs(lane_ofs), .err(err_c), .cnt(cnt_c)
    );

    // Report the correction and issue the send request at the correction point.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            corr_err <= '0;
            corr_stb <= 1'b0;
            unsync   <= 1'b1;
            tx_req   <= 1'b0;
        end else begin
            corr_stb <= corr_due;
            tx_req   <= corr_due && (role == ROLE_COMP_MASTER) && (cnt_c != '0);
            if (corr_due) begin
                corr_err <= err_c;
                unsync   <= (cnt_c == '0);
            end
        end
    end
endmodule

// File: rtl/sync_corr_unit_chk.sv
// Property checker for sync_corr_unit, attached by bind. Observes ports only.
module sync_corr_unit_chk #(
    parameter int TW       = 20,
    parameter int CYCLE_NS = 80000,
    parameter int TICK_NS  = 8,
    parameter int WIN_NS   = 1000
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [TW-1:0]        local_time,
    input logic signed [TW-1:0] corr_err,
    input logic                 corr_stb,
    input logic                 unsync,
    input logic                 tx_req
);
    function automatic int wrap_i(int v);
        if (v >= CYCLE_NS) return v - CYCLE_NS;
        if (v < 0)         return v + CYCLE_NS;
        return v;
    endfunction

    assert_time_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !corr_stb) |->
        (int'(local_time) == wrap_i(int'($past(local_time)) + TICK_NS)));

    assert_time_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
        int'(local_time) < CYCLE_NS);

    assert_err_window_R2: assert property (@(posedge clk) disable iff (!rst_n)
        corr_stb |-> (int'(corr_err) >= -WIN_NS && int'(corr_err) <= WIN_NS));

    assert_apply_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && corr_stb) |->
        (int'(local_time) == wrap_i(int'($past(local_time)) + TICK_NS - int'(corr_err))));

    assert_empty_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (corr_stb && unsync) |-> (corr_err == '0));

    assert_tx_with_stb_R8: assert property (@(posedge clk) disable iff (!rst_n)
        tx_req |-> (corr_stb && !unsync));

    assert_single_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        corr_stb |=> !corr_stb);
endmodule

bind sync_corr_unit sync_corr_unit_chk #(
    .TW(TW), .CYCLE_NS(CYCLE_NS), .TICK_NS(TICK_NS), .WIN_NS(WIN_NS)
) u_chk (
    .clk(clk), .rst_n(rst_n), .local_time(local_time), .corr_err(corr_err),
    .corr_stb(corr_stb), .unsync(unsync), .tx_req(tx_req)
);

// File: tb/sim_sync_corr_unit.sv
module sim_sync_corr_unit;
    localparam int TW = 20, CYC = 8000, SCH = 2000, WIN = 1000, MAXD = 400;
    localparam int CORR = 4400, TICK = 8, NSM = 4, NCH = 2;

    logic clk = 1'b0, rst_n = 1'b0, role_cm = 1'b0;
    logic [NSM-1:0]    frm_vld = '0;
    logic [NSM*TW-1:0] frm_tc = '0;
    wire  [TW-1:0]        local_time;
    wire  signed [TW-1:0] corr_err;
    wire  corr_stb, unsync, tx_req;

    always #4 clk = ~clk;

    sync_corr_unit #(
        .NUM_SM(NSM), .NUM_CH(NCH), .TW(TW), .CYCLE_NS(CYC), .TICK_NS(TICK),
        .SCHED_NS(SCH), .WIN_NS(WIN), .MAXD_NS(MAXD), .CORR_NS(CORR)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .role_cm(role_cm), .frm_vld(frm_vld), .frm_tc(frm_tc),
        .local_time(local_time), .corr_err(corr_err), .corr_stb(corr_stb),
        .unsync(unsync), .tx_req(tx_req)
    );

    int n_chk = 0, n_fail = 0;
    bit pres[NSM], dup[NSM];
    int tgt1[NSM], tgt2[NSM], arr[NSM];

    task automatic chk(bit ok, string req, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int wrapc(int v);
        if (v >= CYC) return v - CYC;
        if (v < 0)    return v + CYC;
        return v;
    endfunction

    task automatic clr();
        for (int i = 0; i < NSM; i++) begin pres[i] = 0; dup[i] = 0; end
    endtask

    // Lane i sends offset t; optionally a second frame with offset t2 (t2 <= t + 80).
    task automatic lane(int i, int t, bit d, int t2);
        pres[i] = 1; dup[i] = d; tgt1[i] = t; tgt2[i] = t2;
        arr[i] = SCH - MAXD + t + int'($urandom_range(0, 300));
    endtask

    // One integration cycle: drive frames, model acceptance, check the correction.
    task automatic run_cycle(bit cm, string tag);
        int stage[NSM]; bit acc[NSM]; int val[NSM];
        int lt_prev, e, cnt, sum, mx, mn, lt, t, prev, extra;
        bit got, stepok;
        role_cm = cm;
        got = 0;
        for (int i = 0; i < NSM; i++) begin stage[i] = 0; acc[i] = 0; val[i] = 0; end
        lt_prev = int'(local_time);
        for (int k = 0; k < 3000 && !got; k++) begin
            @(negedge clk);
            frm_vld = '0;
            if (corr_stb) begin
                got = 1;
                cnt = 0; sum = 0; mx = -100000; mn = 100000;
                for (int i = 0; i < NSM; i++) if (acc[i]) begin
                    cnt++; sum += val[i];
                    if (val[i] > mx) mx = val[i];
                    if (val[i] < mn) mn = val[i];
                end
                case (cnt)
                    0: e = 0;
                    1: e = sum;
                    2: e = sum >>> 1;
                    3: e = sum - mx - mn;
                    default: e = (sum - mx - mn) >>> 1;
                endcase
                $display("%s: frames %0d expected error %0d", tag, cnt, e);
                chk(int'(corr_err) == e, cm ? "R4 error" : "R5 error", int'(corr_err), e);
                chk(unsync == (cnt == 0), "R7 unsync", int'(unsync), int'(cnt == 0));
                chk(tx_req == (cm && cnt > 0), "R8 tx_req", int'(tx_req), int'(cm && cnt > 0));
                chk(int'(local_time) == wrapc(lt_prev + TICK - e), "R6 applied time",
                    int'(local_time), wrapc(lt_prev + TICK - e));
            end else begin
                lt = int'(local_time);
                for (int i = 0; i < NSM; i++) begin
                    if (pres[i] && ((stage[i] == 0 && lt >= arr[i]) ||
                                    (stage[i] == 1 && lt >= arr[i] + 80))) begin
                        t = (stage[i] == 0) ? tgt1[i] : tgt2[i];
                        stage[i] = (stage[i] == 0 && dup[i]) ? 1 : 2;
                        frm_vld[i] = 1'b1;
                        frm_tc[i*TW +: TW] = TW'(lt + MAXD - SCH - t);
                        if ((cm || i < NCH) && !acc[i] && t >= -WIN && t <= WIN) begin
                            acc[i] = 1; val[i] = t;
                        end
                    end
                end
            end
            lt_prev = int'(local_time);
        end
        if (!got) chk(0, "R6 strobe missing", 0, 1);
        extra = 0; stepok = 1; prev = int'(local_time);
        while (int'(local_time) >= 1000) begin
            @(negedge clk);
            if (corr_stb) extra++;
            if (int'(local_time) != wrapc(prev + TICK)) stepok = 0;
            prev = int'(local_time);
        end
        chk(extra == 0, "R10 second correction", extra, 0);
        chk(stepok, "R1 time step", int'(stepok), 1);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(2024));
        repeat (3) @(negedge clk);
        chk(local_time == '0, "R9 local_time", int'(local_time), 0);
        chk(corr_stb == 0 && tx_req == 0, "R9 strobes", int'({corr_stb, tx_req}), 0);
        chk(unsync == 1, "R9 unsync", int'(unsync), 1);
        chk(corr_err == '0, "R9 corr_err", int'(corr_err), 0);
        rst_n = 1'b1;

        clr(); run_cycle(1, "R7 empty cycle");
        clr(); lane(0, -100, 0, 0); lane(1, 50, 0, 0); lane(2, 900, 0, 0); lane(3, 60, 0, 0);
        run_cycle(1, "R4 four with outlier");
        clr(); lane(0, 300, 0, 0); lane(1, -200, 0, 0); lane(3, 10, 0, 0);
        run_cycle(1, "R4 three");
        clr(); lane(0, -3, 0, 0); lane(1, 0, 0, 0); lane(2, 500, 0, 0); lane(3, 500, 0, 0);
        run_cycle(0, "R5 two channels floor");
        clr(); lane(0, -1100, 0, 0); lane(1, 777, 0, 0);
        run_cycle(0, "R5 single channel");
        clr(); lane(0, 1100, 1, 20); lane(1, 5, 1, -300);
        run_cycle(1, "R3 repeated frames");
        clr(); lane(0, 1000, 0, 0); lane(1, -1000, 0, 0); lane(2, 1001, 0, 0);
        run_cycle(1, "R2 window edges");
        clr(); lane(2, -1001, 0, 0);
        run_cycle(1, "R2 outside only");
        clr(); lane(0, 900, 0, 0); lane(1, 700, 0, 0);
        run_cycle(0, "R10 backward jump");

        for (int c = 0; c < 20; c++) begin
            clr();
            for (int i = 0; i < NSM; i++) begin
                if ($urandom_range(0, 3) != 0) begin
                    int t = int'($urandom_range(0, 2400)) - 1200;
                    lane(i, t, $urandom_range(0, 3) == 0, t - int'($urandom_range(0, 800)));
                end
            end
            run_cycle($urandom_range(0, 1) == 1, "random");
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule